// File: doc/BRIEF.md
# Programmable Interlaced Video Timing Generator

This block produces the raster timing for a display output from one clock and a set of static timing inputs. Each scan line is split into four horizontal segments in a fixed order: active, front porch, sync, back porch. Each field is split the same way in lines. There are two independent sets of vertical lengths, one for the even field and one for the odd field. In interlaced scan the two sets alternate field by field. Each set also carries its own vertical-sync delay, so the odd field's vsync can start half a line late. Progressive scan always uses the even set.

The generator drives horizontal sync, vertical sync, data enable and a pixel request. With a repetition factor of two, the pixel request fires once per pair of active clocks. It also reports the current field. A status flag is raised at the first clock of each vertical front porch. That flag is masked by an interrupt enable and cleared by a one-cycle clear strobe. Horizontal lengths are given in output clocks, so software folds the pixel repetition and pixels-per-clock scaling into them before it programs the block. The vertical back porch must be at least one line in both sets, and the vsync delays must be less than the line length.

A rising edge on the enable input starts scanning at the first pixel of the first line. Dropping the enable does not cut a field short: the current field completes, and then the running status drops. Software polls that status before it reconfigures the block. In continuous mode, fields repeat for as long as the enable stays high. Otherwise exactly one field is produced per enable edge.

Top module: `vtg_top`

## Requirements
- R1: While reset is applied and on release, run_o, hsync_o, vsync_o, de_o, pix_req_o, irq_stat_o and irq_o are all 0.
- R2: While running, a line lasts hact_i+hfp_i+hsw_i+hbp_i clocks, counted from position 0. hsync_o is 1 exactly at positions hact_i+hfp_i up to hact_i+hfp_i+hsw_i-1.
- R3: de_o is 1 exactly when the line position is below hact_i and the line index within the field is below the active line count of the field in use. A field lasts the sum of its four vertical lengths in lines.
- R4: Let D be the vsync delay of the field in use and S the index of its first sync line. vsync_o rises at position D of line S and falls at position D of the first line after sync. It is 0 whenever the block is not running.
- R5: field_o reads 0 for the even set and 1 for the odd set. In interlaced mode the first field is even unless odd_first_i is 1, and consecutive fields alternate. In progressive mode the even set is always used and field_o stays 0.
- R6: With pix_rep_i=0, pix_req_o equals de_o. With pix_rep_i=1, pix_req_o is de_o at even line positions only.
- R7: irq_stat_o becomes 1 in the first clock of a field's vertical front porch (position 0 of the first line after the active lines). It stays 1 until the cycle after a clock in which irq_clr_i is 1. A set in the same clock as a clear wins. irq_o is irq_stat_o AND irq_en_i.
- R8: A 0-to-1 change of en_i while idle makes run_o 1 from the next clock, starting at line 0, position 0.
- R9: After en_i drops, output continues to the last clock of the current field. run_o is 0 from the next clock, and no further de_o, hsync_o or vsync_o activity occurs.
- R10: With cont_i=1 and en_i held high, the next field begins at the clock right after the last one with no idle gap. With cont_i=0 exactly one field is produced.
- R11: After a single field in non-continuous mode, a still-high en_i does not restart scanning. Only a new 0-to-1 change does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Video enable request |
| cont_i | input | 1 | Continuous (repeat) mode |
| interlace_i | input | 1 | Interlaced scan select |
| odd_first_i | input | 1 | Start interlaced scan with the odd field |
| pix_rep_i | input | 1 | Pixel repetition by two |
| irq_en_i | input | 1 | Interrupt enable mask |
| irq_clr_i | input | 1 | Interrupt status clear strobe |
| hact_i | input | HW | Active clocks per line |
| hfp_i | input | HW | Horizontal front porch clocks |
| hsw_i | input | HW | Horizontal sync clocks |
| hbp_i | input | HW | Horizontal back porch clocks |
| ev_act_i | input | VW | Even set: active lines |
| ev_fp_i | input | VW | Even set: front porch lines |
| ev_sw_i | input | VW | Even set: sync lines |
| ev_bp_i | input | VW | Even set: back porch lines |
| ev_dly_i | input | HW+2 | Even set: vsync delay in clocks |
| od_act_i | input | VW | Odd set: active lines |
| od_fp_i | input | VW | Odd set: front porch lines |
| od_sw_i | input | VW | Odd set: sync lines |
| od_bp_i | input | VW | Odd set: back porch lines |
| od_dly_i | input | HW+2 | Odd set: vsync delay in clocks |
| run_o | output | 1 | Timing generation running |
| field_o | output | 1 | Current field (1 = odd) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pix_req_o | output | 1 | Pixel request |
| irq_stat_o | output | 1 | Front-porch interrupt status |
| irq_o | output | 1 | Masked interrupt |

## Verification
The position counters are registered. Data enable, hsync, pixel request and field are decoded from them, so they are valid from the first clock after the edge that starts scanning. Vsync and the interrupt status are computed from the next position, so they change in the very clock whose position the requirement names. run_o falls one clock after the final clock of a field, and a clear strobe takes effect one clock after it is sampled. The bench keeps its own arithmetic count of clocks since the start of the field and derives every expected output from that count. It applies inputs and compares all outputs on the falling edge of every clock, across a sweep of horizontal lengths and scan modes.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    typedef enum logic [1:0] {
        SEG_ACT  = 2'd0,
        SEG_FP   = 2'd1,
        SEG_SYNC = 2'd2,
        SEG_BP   = 2'd3
    } seg_e;

    // Segment of a position given the lengths of the first three segments.
    function automatic seg_e seg_of(input logic [31:0] pos,
                                    input logic [31:0] len_act,
                                    input logic [31:0] len_fp,
                                    input logic [31:0] len_sync);
        if (pos < len_act)
            return SEG_ACT;
        else if (pos < len_act + len_fp)
            return SEG_FP;
        else if (pos < len_act + len_fp + len_sync)
            return SEG_SYNC;
        else
            return SEG_BP;
    endfunction

endpackage

// File: rtl/vtg_line_ctr.sv
module vtg_line_ctr
    import vtg_pkg::*;
#(
    parameter int unsigned HW = 12,
    localparam int unsigned PW = HW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          run_i,
    input  logic [HW-1:0] hact_i,
    input  logic [HW-1:0] hfp_i,
    input  logic [HW-1:0] hsw_i,
    input  logic [HW-1:0] hbp_i,
    output logic [PW-1:0] hpos_o,
    output logic [PW-1:0] hpos_nx_o,
    output logic          eol_o,
    output seg_e          hseg_o
);

    typedef struct packed {
        logic [PW-1:0] hpos;
    } line_st_t;

    line_st_t      q, d;
    logic [PW-1:0] htot;
    logic [PW-1:0] hlast;
    logic          eol;

    always_comb begin
        htot  = PW'(hact_i) + PW'(hfp_i) + PW'(hsw_i) + PW'(hbp_i);
        hlast = htot - PW'(1);
        eol   = (q.hpos == hlast);
        d     = q;
        if (start_i)
            d.hpos = '0;
        else if (run_i)
            d.hpos = eol ? '0 : q.hpos + PW'(1);
        else
            d.hpos = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign hpos_o    = q.hpos;
    assign hpos_nx_o = d.hpos;
    assign eol_o     = eol;
    assign hseg_o    = seg_of(32'(q.hpos), 32'(hact_i), 32'(hfp_i), 32'(hsw_i));

    // R2: the line position never passes the programmed line length
    assert_hpos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (q.hpos <= hlast));

endmodule

// File: rtl/vtg_field_ctl.sv
module vtg_field_ctl
    import vtg_pkg::*;
#(
    parameter int unsigned VW = 11,
    parameter int unsigned PW = 14,
    localparam int unsigned VPW = VW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cont_i,
    input  logic          interlace_i,
    input  logic          odd_first_i,
    input  logic          irq_clr_i,
    input  logic          eol_i,
    input  logic [PW-1:0] hpos_nx_i,
    input  logic [VW-1:0] ev_act_i,
    input  logic [VW-1:0] ev_fp_i,
    input  logic [VW-1:0] ev_sw_i,
    input  logic [VW-1:0] ev_bp_i,
    input  logic [PW-1:0] ev_dly_i,
    input  logic [VW-1:0] od_act_i,
    input  logic [VW-1:0] od_fp_i,
    input  logic [VW-1:0] od_sw_i,
    input  logic [VW-1:0] od_bp_i,
    input  logic [PW-1:0] od_dly_i,
    output logic          run_o,
    output logic          start_o,
    output logic          field_o,
    output logic          vsync_o,
    output logic          irq_o,
    output seg_e          vseg_o
);

    typedef struct packed {
        logic           run;
        logic           en_prev;
        logic           field;
        logic           vsync;
        logic           irq;
        logic [VPW-1:0] vpos;
    } fld_st_t;

    fld_st_t        q, d;
    logic [VPW-1:0] ev_tot, od_tot, cur_tot;
    logic [VPW-1:0] cur_act, cur_fp, cur_sw;
    logic [VPW-1:0] nx_act, nx_fp, nx_sw;
    logic [PW-1:0]  nx_dly;
    logic           cur_sel, nx_sel, start, keep, last_line, irq_set;
    seg_e           nx_seg;

    always_comb begin
        ev_tot    = VPW'(ev_act_i) + VPW'(ev_fp_i) + VPW'(ev_sw_i) + VPW'(ev_bp_i);
        od_tot    = VPW'(od_act_i) + VPW'(od_fp_i) + VPW'(od_sw_i) + VPW'(od_bp_i);
        cur_sel   = interlace_i & q.field;
        cur_tot   = cur_sel ? od_tot : ev_tot;
        cur_act   = cur_sel ? VPW'(od_act_i) : VPW'(ev_act_i);
        cur_fp    = cur_sel ? VPW'(od_fp_i)  : VPW'(ev_fp_i);
        cur_sw    = cur_sel ? VPW'(od_sw_i)  : VPW'(ev_sw_i);
        last_line = (q.vpos == cur_tot - VPW'(1));
        start     = ~q.run & en_i & ~q.en_prev;
        keep      = cont_i & en_i;

        d         = q;
        d.en_prev = en_i;
        if (start) begin
            d.run   = 1'b1;
            d.vpos  = '0;
            d.field = interlace_i & odd_first_i;
        end else if (q.run && eol_i) begin
            if (last_line) begin
                d.vpos = '0;
                if (keep)
                    d.field = interlace_i & ~q.field;
                else
                    d.run = 1'b0;
            end else begin
                d.vpos = q.vpos + VPW'(1);
            end
        end

        // Look ahead at the next position so vsync and irq land on it exactly.
        nx_sel = interlace_i & d.field;
        nx_act = nx_sel ? VPW'(od_act_i) : VPW'(ev_act_i);
        nx_fp  = nx_sel ? VPW'(od_fp_i)  : VPW'(ev_fp_i);
        nx_sw  = nx_sel ? VPW'(od_sw_i)  : VPW'(ev_sw_i);
        nx_dly = nx_sel ? od_dly_i : ev_dly_i;
        nx_seg = seg_of(32'(d.vpos), 32'(nx_act), 32'(nx_fp), 32'(nx_sw));

        if (!d.run)
            d.vsync = 1'b0;
        else if (hpos_nx_i == nx_dly)
            d.vsync = (nx_seg == SEG_SYNC);

        irq_set = d.run & (hpos_nx_i == '0) & (d.vpos == nx_act);
        d.irq   = irq_set | (q.irq & ~irq_clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign run_o   = q.run;
    assign start_o = start;
    assign field_o = q.field;
    assign vsync_o = q.vsync;
    assign irq_o   = q.irq;
    assign vseg_o  = seg_of(32'(q.vpos), 32'(cur_act), 32'(cur_fp), 32'(cur_sw));

    // R8: scanning always begins on the first line
    assert_start_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.run) |-> (q.vpos == '0));

    // R9: scanning only ends after the last clock of a field
    assert_stop_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.run) |-> $past(eol_i && last_line));

    // R7: the status only rises on the first front-porch line
    assert_irq_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.irq) |-> (q.run && (q.vpos == cur_act)));

    // R4: no vertical sync while idle
    assert_vsync_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !q.run |-> !q.vsync);

    // R5: interlaced fields alternate across a field boundary
    assert_field_alt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && $past(q.run) && $past(eol_i && last_line) && interlace_i)
            |-> (q.field != $past(q.field)));

endmodule

// File: rtl/vtg_top.sv
module vtg_top
    import vtg_pkg::*;
#(
    parameter int unsigned HW = 12,
    parameter int unsigned VW = 11,
    localparam int unsigned PW = HW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          cont_i,
    input  logic          interlace_i,
    input  logic          odd_first_i,
    input  logic          pix_rep_i,
    input  logic          irq_en_i,
    input  logic          irq_clr_i,
    input  logic [HW-1:0] hact_i,
    input  logic [HW-1:0] hfp_i,
    input  logic [HW-1:0] hsw_i,
    input  logic [HW-1:0] hbp_i,
    input  logic [VW-1:0] ev_act_i,
    input  logic [VW-1:0] ev_fp_i,
    input  logic [VW-1:0] ev_sw_i,
    input  logic [VW-1:0] ev_bp_i,
    input  logic [PW-1:0] ev_dly_i,
    input  logic [VW-1:0] od_act_i,
    input  logic [VW-1:0] od_fp_i,
    input  logic [VW-1:0] od_sw_i,
    input  logic [VW-1:0] od_bp_i,
    input  logic [PW-1:0] od_dly_i,
    output logic          run_o,
    output logic          field_o,
    output logic          hsync_o,
    output logic          vsync_o,
    output logic          de_o,
    output logic          pix_req_o,
    output logic          irq_stat_o,
    output logic          irq_o
);

    logic [PW-1:0] hpos, hpos_nx;
    logic          eol, start, run;
    seg_e          hseg, vseg;

    vtg_line_ctr #(.HW(HW)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .run_i     (run),
        .hact_i    (hact_i),
        .hfp_i     (hfp_i),
        .hsw_i     (hsw_i),
        .hbp_i     (hbp_i),
        .hpos_o    (hpos),
        .hpos_nx_o (hpos_nx),
        .eol_o     (eol),
        .hseg_o    (hseg)
    );

    vtg_field_ctl #(.VW(VW), .PW(PW)) u_field (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en_i),
        .cont_i      (cont_i),
        .interlace_i (interlace_i),
        .odd_first_i (odd_first_i),
        .irq_clr_i   (irq_clr_i),
        .eol_i       (eol),
        .hpos_nx_i   (hpos_nx),
        .ev_act_i    (ev_act_i),
        .ev_fp_i     (ev_fp_i),
        .ev_sw_i     (ev_sw_i),
        .ev_bp_i     (ev_bp_i),
        .ev_dly_i    (ev_dly_i),
        .od_act_i    (od_act_i),
        .od_fp_i     (od_fp_i),
        .od_sw_i     (od_sw_i),
        .od_bp_i     (od_bp_i),
        .od_dly_i    (od_dly_i),
        .run_o       (run),
        .start_o     (start),
        .field_o     (field_o),
        .vsync_o     (vsync_o),
        .irq_o       (irq_stat_o),
        .vseg_o      (vseg)
    );

    always_comb begin
        run_o     = run;
        de_o      = run & (hseg == SEG_ACT) & (vseg == SEG_ACT);
        hsync_o   = run & (hseg == SEG_SYNC);
        pix_req_o = de_o & (~pix_rep_i | ~hpos[0]);
        irq_o     = irq_stat_o & irq_en_i;
    end

endmodule

// File: tb/tb_vtg_top.sv
`timescale 1ns/1ps
module tb_vtg_top;

    localparam int HW = 12;
    localparam int VW = 11;
    localparam int PW = HW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0, cont_i = 1'b0, interlace_i = 1'b0, odd_first_i = 1'b0;
    logic pix_rep_i = 1'b0, irq_en_i = 1'b0, irq_clr_i = 1'b1;
    logic [HW-1:0] hact_i = '0, hfp_i = '0, hsw_i = '0, hbp_i = '0;
    logic [VW-1:0] ev_act_i = '0, ev_fp_i = '0, ev_sw_i = '0, ev_bp_i = '0;
    logic [VW-1:0] od_act_i = '0, od_fp_i = '0, od_sw_i = '0, od_bp_i = '0;
    logic [PW-1:0] ev_dly_i = '0, od_dly_i = '0;
    logic run_o, field_o, hsync_o, vsync_o, de_o, pix_req_o, irq_stat_o, irq_o;

    always #2 clk = ~clk;

    vtg_top #(.HW(HW), .VW(VW)) dut (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .cont_i(cont_i),
        .interlace_i(interlace_i), .odd_first_i(odd_first_i), .pix_rep_i(pix_rep_i),
        .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
        .hact_i(hact_i), .hfp_i(hfp_i), .hsw_i(hsw_i), .hbp_i(hbp_i),
        .ev_act_i(ev_act_i), .ev_fp_i(ev_fp_i), .ev_sw_i(ev_sw_i), .ev_bp_i(ev_bp_i),
        .ev_dly_i(ev_dly_i),
        .od_act_i(od_act_i), .od_fp_i(od_fp_i), .od_sw_i(od_sw_i), .od_bp_i(od_bp_i),
        .od_dly_i(od_dly_i),
        .run_o(run_o), .field_o(field_o), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .pix_req_o(pix_req_o), .irq_stat_o(irq_stat_o), .irq_o(irq_o)
    );

    int checks = 0;
    int errors = 0;

    // configuration of the case in progress
    int ha, hf, hs, hb, htot;
    int ev_v[4] = '{3, 1, 2, 1};
    int od_v[4] = '{3, 1, 2, 2};
    int ev_d, od_d;
    int il, cn, rp, oddf;

    // bench-side expectation state
    int m_run = 0, m_off = 0, m_fld = 0, m_irq = 0, m_enp = 0, m_fields = 0;
    int en_now = 0, clr_now = 1, ien_now = 0;

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int vset(input int f, input int k);
        return (il != 0 && f != 0) ? od_v[k] : ev_v[k];
    endfunction

    function automatic int flen(input int f);
        return htot * (vset(f, 0) + vset(f, 1) + vset(f, 2) + vset(f, 3));
    endfunction

    task automatic compare_now(input string run_tag);
        int h, v, e_de, e_hs, e_vs, e_pr, d, lo, hi;
        h = m_off % htot;
        v = m_off / htot;
        d = (il != 0 && m_fld != 0) ? od_d : ev_d;
        lo = (vset(m_fld, 0) + vset(m_fld, 1)) * htot + d;
        hi = (vset(m_fld, 0) + vset(m_fld, 1) + vset(m_fld, 2)) * htot + d;
        e_de = (m_run != 0 && v < vset(m_fld, 0) && h < ha) ? 1 : 0;
        e_hs = (m_run != 0 && h >= ha + hf && h < ha + hf + hs) ? 1 : 0;
        e_vs = (m_run != 0 && m_off >= lo && m_off < hi) ? 1 : 0;
        e_pr = (e_de != 0 && (rp == 0 || (h % 2) == 0)) ? 1 : 0;
        chk(int'(run_o), m_run, run_tag);
        chk(int'(de_o), e_de, "R3 data enable");
        chk(int'(hsync_o), e_hs, "R2 hsync");
        chk(int'(vsync_o), e_vs, "R4 vsync");
        chk(int'(pix_req_o), e_pr, "R6 pixel request");
        chk(int'(irq_stat_o), m_irq, "R7 irq status");
        chk(int'(irq_o), m_irq & ien_now, "R7 irq masked");
        if (m_run != 0)
            chk(int'(field_o), m_fld, "R5 field");
    endtask

    task automatic advance_model();
        int nrun, noff, nfld;
        nrun = m_run; noff = m_off; nfld = m_fld;
        if (m_run == 0) begin
            if (en_now != 0 && m_enp == 0) begin
                nrun = 1; noff = 0; nfld = (il != 0 && oddf != 0) ? 1 : 0;
            end
        end else if (m_off + 1 == flen(m_fld)) begin
            noff = 0;
            if (cn != 0 && en_now != 0) begin
                nfld = (il != 0) ? 1 - m_fld : 0;
                m_fields++;
            end else begin
                nrun = 0;
            end
        end else begin
            noff = m_off + 1;
        end
        if (nrun != 0 && noff == vset(nfld, 0) * htot)
            m_irq = 1;
        else if (clr_now != 0)
            m_irq = 0;
        m_run = nrun; m_off = noff; m_fld = nfld; m_enp = en_now;
    endtask

    task automatic run_case(input int a, input int f, input int s, input int b,
                            input int ilv, input int cnv, input int rpv, input int ofv,
                            input int iev, input int clrv);
        int started, idle, run_cyc, exp_cyc;
        string tag;
        @(negedge clk);
        ha = a; hf = f; hs = s; hb = b; htot = a + f + s + b;
        il = ilv; cn = cnv; rp = rpv; oddf = ofv;
        ev_d = (il != 0) ? 0 : a;
        od_d = htot / 2;
        hact_i = HW'(a); hfp_i = HW'(f); hsw_i = HW'(s); hbp_i = HW'(b);
        ev_act_i = VW'(ev_v[0]); ev_fp_i = VW'(ev_v[1]); ev_sw_i = VW'(ev_v[2]); ev_bp_i = VW'(ev_v[3]);
        od_act_i = VW'(od_v[0]); od_fp_i = VW'(od_v[1]); od_sw_i = VW'(od_v[2]); od_bp_i = VW'(od_v[3]);
        ev_dly_i = PW'(ev_d); od_dly_i = PW'(od_d);
        interlace_i = il[0]; cont_i = cn[0]; pix_rep_i = rp[0]; odd_first_i = oddf[0];
        irq_en_i = iev[0]; ien_now = iev;
        irq_clr_i = clrv[0]; clr_now = clrv;
        started = 0; idle = 0; run_cyc = 0; m_fields = 0;
        exp_cyc = (cn != 0) ? 0 : -1;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc > 0) @(negedge clk);
            if (m_run != 0) tag = "R8 running";
            else if (started != 0 && en_now != 0) tag = "R11 no retrigger";
            else tag = "R9 stopped";
            compare_now(tag);
            if (run_o) run_cyc++;
            if (m_run != 0) started = 1;
            if (started != 0 && m_run == 0) idle++;
            // drive the enable
            if (cyc == 0) en_now = 1;
            if (cn != 0 && m_run != 0 && m_fields == 2 && m_off == flen(m_fld) / 2)
                en_now = 0;
            if (cn == 0 && idle >= 10) en_now = 0;
            en_i = en_now[0];
            if (idle >= 13) break;
            advance_model();
        end
        // R10: total running clocks equal the expected field lengths
        if (cn != 0) begin
            exp_cyc = 0;
            for (int k = 0; k < 3; k++)
                exp_cyc += flen((il != 0) ? ((oddf + k) % 2) : 0);
        end else begin
            exp_cyc = flen((il != 0 && oddf != 0) ? 1 : 0);
        end
        chk(run_cyc, exp_cyc, "R10 running clock count");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(int'(run_o), 0, "R1 run");
        chk(int'(de_o | hsync_o | vsync_o | pix_req_o), 0, "R1 video outputs");
        chk(int'(irq_stat_o | irq_o), 0, "R1 irq");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(run_o | de_o | hsync_o | vsync_o | irq_stat_o), 0, "R1 after release");

        // sweep over small horizontal shapes and the four scan modes
        for (int ilv = 0; ilv < 2; ilv++)
            for (int cnv = 0; cnv < 2; cnv++)
                for (int ai = 0; ai < 2; ai++)
                    for (int fi = 1; fi <= 2; fi++)
                        for (int si = 1; si <= 2; si++)
                            for (int bi = 0; bi < 2; bi++)
                                run_case(ai != 0 ? 5 : 2, fi, si, bi != 0 ? 3 : 1,
                                         ilv, cnv, (fi == 2) ? 1 : 0, (si == 2) ? 1 : 0,
                                         bi, 1);

        // R7: status holds without a clear, the mask gates it, a clear drops it
        run_case(3, 1, 2, 2, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk(int'(irq_stat_o), 1, "R7 status held while idle");
        chk(int'(irq_o), 0, "R7 masked off");
        irq_en_i = 1'b1;
        #1;
        chk(int'(irq_o), 1, "R7 mask on");
        @(negedge clk);
        irq_clr_i = 1'b1;
        @(negedge clk);
        chk(int'(irq_stat_o), 0, "R7 cleared after strobe");
        chk(int'(irq_o), 0, "R7 masked output cleared");
        m_irq = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule